// File: doc/BRIEF.md
# Multiport Host Mailbox Buffer Controller

This block lets a host processor trade framed packets with up to four line ports through shared buffer memory. The host sees a 32-bit memory-mapped bus with two regions. The first is a 128-byte configuration window that holds a flags word, an interrupt enable, an interrupt acknowledge, a read-only version word and general scratch storage. The second is a data window with one receive buffer and one transmit buffer per port. Each buffer holds a packet made of an 8-byte header followed by its payload. The header has four little-endian 16-bit fields: length, path id, channel id and kind. The kind codes are 0 for data, 1 for console text, 3 for channel open and 4 for channel close.

Ownership of each buffer passes through the flags word. The host loads a transmit buffer and then writes a 1 to that port's transmit bit, which marks the buffer busy. The port reads the buffer and signals that it has taken it, and the busy bit then clears. On the receive side, the port writes a packet into its receive buffer and signals completion, which sets the receive-ready bit. The host reads the packet and writes a 1 to that bit to hand the buffer back. A single level interrupt tells the host when a receive buffer fills or a transmit buffer is released.

Host address bit `HAW-1` selects the data window when 1 and the configuration window when 0. The buffer size is the parameter `BUF_BYTES`, whose default of 256 keeps the memories small. A value of 4096 gives the full 32 KB layout.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset, every flag bit, the interrupt enable, the pending interrupt, the `irq` output and all scratch words in the configuration window are zero.
- R2: In the configuration window, byte offsets 0x00–0x6C are read/write scratch words. Offset 0x74 reads `{VER_MAJOR[7:0], VER_MINOR[7:0], VER_BUILD[15:0]}` and ignores writes. Offset 0x70 reads zero. Offset 0x78 reads back only bit 0, the interrupt enable.
- R3: Offset 0x7C is the flags word: bits [3:0] are transmit-busy for ports 0–3 and bits [7:4] are receive-ready, with port n at bit 4+n. Writing a 1 to bit n (n<4) sets transmit-busy for port n, and writing 0 to any bit leaves it unchanged.
- R4: A `d_tx_take[n]` sampled high while port n is busy makes its busy bit read 0 from the next cycle. If the host sets the same bit in that cycle, the bit stays set.
- R5: A `d_rx_done[n]` sampled high while receive-ready n is clear sets that bit. Writing a 1 to flags bit 4+n clears it.
- R6: While receive-ready n is set, `d_rx_stall[n]` is high and that port's buffer writes and done pulses are refused, so the buffer contents and the flag are left unchanged.
- R7: An interrupt becomes pending when any receive-ready bit rises or any transmit-busy bit falls. Any write to offset 0x70 clears it, but a new event in the same cycle keeps it pending.
- R8: `irq` is high exactly while an interrupt is pending and the enable bit is 1. A pending interrupt survives while the enable is 0.
- R9: In the data window, port n's receive buffer starts at byte n*2*BUF_BYTES and its transmit buffer at n*2*BUF_BYTES+BUF_BYTES. The host reads receive words as the port wrote them and writes transmit words, which the port reads on `d_tx_rdata` one cycle after presenting their word address. Host reads of transmit buffers return zero.
- R10: A host read sampled in cycle t has `h_rvalid` high and its data on `h_rdata` in cycle t+1; writes never raise `h_rvalid`.
- R11: For ports numbered NPORTS and above, flag bits read zero and ignore writes, and reads of their buffers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | HAW | Host byte address; top bit selects the data window |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read data valid |
| h_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt to host |
| d_tx_busy | output | NPORTS | Transmit buffer owned by port |
| d_tx_take | input | NPORTS | Port has taken its transmit buffer |
| d_tx_raddr | input | NPORTS*BWA | Per-port transmit buffer word address |
| d_tx_rdata | output | NPORTS*32 | Per-port transmit buffer read data |
| d_rx_we | input | NPORTS | Per-port receive buffer write |
| d_rx_waddr | input | NPORTS*BWA | Per-port receive buffer word address |
| d_rx_wdata | input | NPORTS*32 | Per-port receive buffer write data |
| d_rx_done | input | NPORTS | Port has finished writing a packet |
| d_rx_stall | output | NPORTS | Receive buffer held by host; deposit refused |

## Verification
The assertions assume that a port pulses `d_tx_take` only while its busy bit is set, and that the host does not read a receive buffer while the port is still writing it. The bench keeps to these assumptions: it drives take only after setting busy, and it reads receive words only after the done pulse. The one deliberate exception is a deposit attempted during stall, which exists to show the refusal. Every stimulus change is made at the falling clock edge, so each register sees one clean sample.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MAX_PORTS = 4;
  localparam int CFG_BYTES = 128;
  localparam int PORT_SEL_W = $clog2(MAX_PORTS);

  // word indices inside the configuration window (offset / 4)
  localparam logic [4:0] IDX_ACK   = 5'd28;
  localparam logic [4:0] IDX_VER   = 5'd29;
  localparam logic [4:0] IDX_EN    = 5'd30;
  localparam logic [4:0] IDX_FLAGS = 5'd31;

  typedef struct packed {
    logic [MAX_PORTS-1:0] rx;
    logic [MAX_PORTS-1:0] tx;
  } flag_word_t;
endpackage

// File: rtl/mbox_sdp_ram.sv
module mbox_sdp_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_flags,
  input  logic [7:0]        wdata,
  input  logic              wr_ack,
  input  logic              wr_en,
  input  logic              en_bit,
  input  logic [NPORTS-1:0] tx_take,
  input  logic [NPORTS-1:0] rx_done,
  output logic [NPORTS-1:0] tx_busy,
  output logic [NPORTS-1:0] rx_ready,
  output logic              irq_en,
  output logic              irq
);
  logic [NPORTS-1:0] set_tx, clr_rx, tx_d, rx_d, tx_q, rx_q;
  logic              pend_d, pend_q, en_d, en_q, irq_q;

  assign set_tx = wr_flags ? wdata[NPORTS-1:0]   : '0;
  assign clr_rx = wr_flags ? wdata[4 +: NPORTS]  : '0;

  always_comb begin
    tx_d   = (tx_q & ~tx_take) | set_tx;
    rx_d   = (rx_q & ~clr_rx) | (rx_done & ~rx_q);
    pend_d = (pend_q & ~wr_ack) | (|(rx_d & ~rx_q)) | (|(tx_q & ~tx_d));
    en_d   = wr_en ? en_bit : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= pend_d & en_d;
    end
  end

  assign tx_busy  = tx_q;
  assign rx_ready = rx_q;
  assign irq_en   = en_q;
  assign irq      = irq_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    p_take_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (tx_take[p] && tx_q[p] && !set_tx[p]) |=> !tx_q[p]);
    p_done_sets_r5: assert property (@(posedge clk) disable iff (rst)
      (rx_done[p] && !rx_q[p]) |=> rx_q[p]);
    p_ready_holds_r6: assert property (@(posedge clk) disable iff (rst)
      (rx_q[p] && !clr_rx[p]) |=> rx_q[p]);
    p_rx_rise_pends_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_q[p]) |-> pend_q);
    p_tx_fall_pends_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(tx_q[p]) |-> pend_q);
  end

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq_q);
  p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> pend_q);
endmodule

// File: rtl/mbox_cfg.sv
module mbox_cfg import mbox_pkg::*; #(
  parameter int          NPORTS    = 4,
  parameter logic [7:0]  VER_MAJOR = 8'd1,
  parameter logic [7:0]  VER_MINOR = 8'd0,
  parameter logic [15:0] VER_BUILD = 16'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [6:0]        ofs,
  input  logic [31:0]       wdata,
  input  logic [NPORTS-1:0] tx_busy,
  input  logic [NPORTS-1:0] rx_ready,
  input  logic              irq_en,
  output logic              wr_flags,
  output logic              wr_ack,
  output logic              wr_en,
  output logic [31:0]       rdata
);
  localparam int          NSCR     = CFG_BYTES / 4 - 4;
  localparam logic [31:0] VER_WORD = {VER_MAJOR, VER_MINOR, VER_BUILD};

  logic [4:0]  widx;
  logic        wr_any;
  logic [31:0] scratch [NSCR];
  logic [31:0] rd_d;
  flag_word_t  fw;
  logic        unused_ofs;

  assign widx       = ofs[6:2];
  assign unused_ofs = ^ofs[1:0];
  assign wr_any     = req & we;
  assign wr_flags   = wr_any && (widx == IDX_FLAGS);
  assign wr_ack     = wr_any && (widx == IDX_ACK);
  assign wr_en      = wr_any && (widx == IDX_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSCR; i++) scratch[i] <= '0;
    end else if (wr_any && (int'(widx) < NSCR)) begin
      scratch[widx] <= wdata;
    end
  end

  always_comb begin
    fw = '0;
    fw.tx[NPORTS-1:0] = tx_busy;
    fw.rx[NPORTS-1:0] = rx_ready;
    case (widx)
      IDX_FLAGS: rd_d = {24'd0, fw};
      IDX_EN:    rd_d = {31'd0, irq_en};
      IDX_VER:   rd_d = VER_WORD;
      IDX_ACK:   rd_d = '0;
      default:   rd_d = scratch[widx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata <= '0;
    else if (req && !we) rdata <= rd_d;
  end

  p_version_ro_r2: assert property (@(posedge clk) disable iff (rst)
    (req && !we && widx == IDX_VER) |=> (rdata == VER_WORD));
  p_ack_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (req && !we && widx == IDX_ACK) |=> (rdata == 32'd0));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl import mbox_pkg::*; #(
  parameter int          NPORTS    = 4,
  parameter int          BUF_BYTES = 256,
  parameter logic [7:0]  VER_MAJOR = 8'd1,
  parameter logic [7:0]  VER_MINOR = 8'd0,
  parameter logic [15:0] VER_BUILD = 16'd0,
  localparam int BAW     = $clog2(BUF_BYTES),
  localparam int BWA     = BAW - 2,
  localparam int DWIN_AW = BAW + 1 + PORT_SEL_W,
  localparam int HAW     = DWIN_AW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  h_req,
  input  logic                  h_we,
  input  logic [HAW-1:0]        h_addr,
  input  logic [31:0]           h_wdata,
  output logic                  h_rvalid,
  output logic [31:0]           h_rdata,
  output logic                  irq,
  output logic [NPORTS-1:0]     d_tx_busy,
  input  logic [NPORTS-1:0]     d_tx_take,
  input  logic [NPORTS*BWA-1:0] d_tx_raddr,
  output logic [NPORTS*32-1:0]  d_tx_rdata,
  input  logic [NPORTS-1:0]     d_rx_we,
  input  logic [NPORTS*BWA-1:0] d_rx_waddr,
  input  logic [NPORTS*32-1:0]  d_rx_wdata,
  input  logic [NPORTS-1:0]     d_rx_done,
  output logic [NPORTS-1:0]     d_rx_stall
);
  logic                  is_dat, cfg_hit, cfg_req, d_tx;
  logic [PORT_SEL_W-1:0] d_port;
  logic [BWA-1:0]        d_word;
  logic                  wr_flags, wr_ack, wr_en, irq_en;
  logic [NPORTS-1:0]     tx_busy, rx_ready;
  logic [31:0]           cfg_rdata;
  logic [31:0]           rx_rd [MAX_PORTS];
  logic                  rvalid_q, rd_dat_q, rd_tx_q;
  logic [PORT_SEL_W-1:0] rd_port_q;
  logic                  unused_addr;

  assign is_dat      = h_addr[HAW-1];
  assign cfg_hit     = !is_dat && (h_addr[HAW-2:7] == '0);
  assign cfg_req     = h_req && cfg_hit;
  assign d_port      = h_addr[DWIN_AW-1 -: PORT_SEL_W];
  assign d_tx        = h_addr[BAW];
  assign d_word      = h_addr[BAW-1:2];
  assign unused_addr = ^h_addr[1:0];

  mbox_cfg #(
    .NPORTS(NPORTS), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .VER_BUILD(VER_BUILD)
  ) u_cfg (
    .clk(clk), .rst(rst), .req(cfg_req), .we(h_we), .ofs(h_addr[6:0]), .wdata(h_wdata),
    .tx_busy(tx_busy), .rx_ready(rx_ready), .irq_en(irq_en),
    .wr_flags(wr_flags), .wr_ack(wr_ack), .wr_en(wr_en), .rdata(cfg_rdata)
  );

  mbox_flags #(.NPORTS(NPORTS)) u_flags (
    .clk(clk), .rst(rst), .wr_flags(wr_flags), .wdata(h_wdata[7:0]), .wr_ack(wr_ack),
    .wr_en(wr_en), .en_bit(h_wdata[0]), .tx_take(d_tx_take), .rx_done(d_rx_done),
    .tx_busy(tx_busy), .rx_ready(rx_ready), .irq_en(irq_en), .irq(irq)
  );

  assign d_tx_busy  = tx_busy;
  assign d_rx_stall = rx_ready;

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
    if (p < NPORTS) begin : g_live
      logic tx_wr, rx_wr;
      assign tx_wr = h_req && h_we && is_dat && d_tx && (d_port == PORT_SEL_W'(p));
      assign rx_wr = d_rx_we[p] && !rx_ready[p];

      mbox_sdp_ram #(.AW(BWA), .DW(32)) u_txbuf (
        .clk(clk), .we(tx_wr), .waddr(d_word), .wdata(h_wdata),
        .raddr(d_tx_raddr[p*BWA +: BWA]), .rdata(d_tx_rdata[p*32 +: 32])
      );
      mbox_sdp_ram #(.AW(BWA), .DW(32)) u_rxbuf (
        .clk(clk), .we(rx_wr), .waddr(d_rx_waddr[p*BWA +: BWA]),
        .wdata(d_rx_wdata[p*32 +: 32]), .raddr(d_word), .rdata(rx_rd[p])
      );

      p_stall_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (d_rx_stall[p] && !wr_flags) |=> d_rx_stall[p]);
    end else begin : g_absent
      assign rx_rd[p] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      rd_dat_q  <= 1'b0;
      rd_tx_q   <= 1'b0;
      rd_port_q <= '0;
    end else begin
      rvalid_q <= h_req && !h_we;
      if (h_req && !h_we) begin
        rd_dat_q  <= is_dat;
        rd_tx_q   <= d_tx;
        rd_port_q <= d_port;
      end
    end
  end

  always_comb begin
    if (!rd_dat_q)                       h_rdata = cfg_rdata;
    else if (rd_tx_q)                    h_rdata = '0;
    else if (int'(rd_port_q) >= NPORTS)  h_rdata = '0;
    else                                 h_rdata = rx_rd[rd_port_q];
  end

  assign h_rvalid = rvalid_q;

  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    (h_req && !h_we) |=> h_rvalid);
  p_write_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (!h_req || h_we) |=> !h_rvalid);
endmodule

// File: tb/mbox_ctrl_test.sv
`timescale 1ns/1ps
module mbox_ctrl_test;
  localparam int NP  = 3;
  localparam int BB  = 256;
  localparam int BWA = 6;
  localparam int HAW = 12;
  localparam logic [31:0] VER = 32'h0205_004D;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              h_req = 1'b0, h_we = 1'b0;
  logic [HAW-1:0]    h_addr = '0;
  logic [31:0]       h_wdata = '0;
  logic              h_rvalid, irq;
  logic [31:0]       h_rdata;
  logic [NP-1:0]     d_tx_busy, d_rx_stall;
  logic [NP-1:0]     d_tx_take = '0, d_rx_we = '0, d_rx_done = '0;
  logic [NP*BWA-1:0] d_tx_raddr = '0, d_rx_waddr = '0;
  logic [NP*32-1:0]  d_tx_rdata;
  logic [NP*32-1:0]  d_rx_wdata = '0;

  int nchk = 0, nerr = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  mbox_ctrl #(.NPORTS(NP), .BUF_BYTES(BB), .VER_MAJOR(8'd2), .VER_MINOR(8'd5),
              .VER_BUILD(16'd77)) uut (
    .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata), .irq(irq), .d_tx_busy(d_tx_busy),
    .d_tx_take(d_tx_take), .d_tx_raddr(d_tx_raddr), .d_tx_rdata(d_tx_rdata),
    .d_rx_we(d_rx_we), .d_rx_waddr(d_rx_waddr), .d_rx_wdata(d_rx_wdata),
    .d_rx_done(d_rx_done), .d_rx_stall(d_rx_stall)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [HAW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0;
  endtask

  task automatic hr(input logic [HAW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b0; h_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    h_req = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && h_rvalid) begin
      if (exp_q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R10 stray rvalid act=%h exp=none", h_rdata);
      end else begin
        chk(h_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 8);
    nerr++; nchk++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({31'd0, irq}, 0, "R1 irq");
    chk({29'd0, d_tx_busy}, 0, "R1 tx_busy");
    chk({29'd0, d_rx_stall}, 0, "R1 rx_stall");
    hr(12'h07C, 32'h0, "R1 flags");
    hr(12'h078, 32'h0, "R1 enable");
    hr(12'h010, 32'h0, "R1 scratch");
    // R2 config window
    hw(12'h010, 32'hA5A5_1234);
    hr(12'h010, 32'hA5A5_1234, "R2 scratch");
    hw(12'h074, 32'hFFFF_FFFF);
    hr(12'h074, VER, "R2 version");
    hr(12'h070, 32'h0, "R2 ack zero");
    // R3 / R11 set busy, absent bit 3 ignored
    hw(12'h07C, 32'h0000_000F);
    chk({29'd0, d_tx_busy}, 32'h7, "R3 tx set");
    hw(12'h07C, 32'h0);
    hr(12'h07C, 32'h07, "R3 R11 flags");
    // R8 enable readback (bit 0 only)
    hw(12'h078, 32'hFFFF_FFFF);
    hr(12'h078, 32'h1, "R2 R8 enable");
    chk({31'd0, irq}, 0, "R8 idle");
    // R4 take clears port1, R7 falling busy interrupts
    @(negedge clk); d_tx_take = 3'b010;
    @(negedge clk); d_tx_take = '0;
    chk({29'd0, d_tx_busy}, 32'h5, "R4 take");
    chk({31'd0, irq}, 1, "R7 tx fall irq");
    hr(12'h07C, 32'h05, "R4 flags");
    hw(12'h070, 32'h0);
    chk({31'd0, irq}, 0, "R7 ack");
    // R4 simultaneous host set and take on port0
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b1; h_addr = 12'h07C; h_wdata = 32'h1; d_tx_take = 3'b001;
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0; d_tx_take = '0;
    chk({29'd0, d_tx_busy}, 32'h5, "R4 set wins");
    chk({31'd0, irq}, 0, "R4 no fall");
    // R9 transmit buffer port2 word 3
    hw(12'hD0C, 32'hCAFE_F00D);
    @(negedge clk); d_tx_raddr[2*BWA +: BWA] = 6'd3;
    @(negedge clk);
    chk(d_tx_rdata[64 +: 32], 32'hCAFE_F00D, "R9 tx read");
    hr(12'hD0C, 32'h0, "R9 tx host read");
    // R5 / R9 receive deposit port1 word 5
    @(negedge clk);
    d_rx_we = 3'b010; d_rx_waddr[BWA +: BWA] = 6'd5; d_rx_wdata[32 +: 32] = 32'h1122_3344;
    @(negedge clk); d_rx_we = '0; d_rx_done = 3'b010;
    @(negedge clk); d_rx_done = '0;
    chk({29'd0, d_rx_stall}, 32'h2, "R5 ready");
    chk({31'd0, irq}, 1, "R7 rx rise irq");
    hr(12'hA14, 32'h1122_3344, "R9 rx read");
    // R6 refused deposit while stalled
    @(negedge clk);
    d_rx_we = 3'b010; d_rx_wdata[32 +: 32] = 32'hDEAD_BEEF; d_rx_done = 3'b010;
    @(negedge clk); d_rx_we = '0; d_rx_done = '0;
    hr(12'hA14, 32'h1122_3344, "R6 refused");
    chk({29'd0, d_rx_stall}, 32'h2, "R6 stall held");
    hr(12'h07C, 32'h25, "R5 flags");
    // R5 release, falling ready no interrupt
    hw(12'h070, 32'h0);
    hw(12'h07C, 32'h20);
    chk({29'd0, d_rx_stall}, 0, "R5 clear");
    chk({31'd0, irq}, 0, "R7 rx fall quiet");
    // R7 ack and new event same cycle: stays pending
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b1; h_addr = 12'h070; d_rx_done = 3'b001;
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0; d_rx_done = '0;
    chk({31'd0, irq}, 1, "R7 set wins");
    hw(12'h078, 32'h0);
    chk({31'd0, irq}, 0, "R8 disabled");
    hw(12'h070, 32'h0);
    hw(12'h07C, 32'h10);
    // R8 pending while disabled, shown on enable
    @(negedge clk); d_rx_done = 3'b100;
    @(negedge clk); d_rx_done = '0;
    chk({31'd0, irq}, 0, "R8 masked");
    hw(12'h078, 32'h1);
    chk({31'd0, irq}, 1, "R8 unmasked");
    // R11 absent port 3
    hw(12'h07C, 32'h88);
    hr(12'h07C, 32'h45, "R11 flags");
    hr(12'hE00, 32'h0, "R11 rx absent");
    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R10 queue drained");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule